// File: doc/BRIEF.md
# Prefixed Instruction Stream Framer

The framer sits behind the instruction-fetch path of an 8-bit processor. It takes the raw byte stream one byte per valid/ready handshake and cuts it into whole instructions. Three byte values act as page-switch prefixes rather than opcodes. Each real opcode is classified by addressing mode, and the matching number of operand bytes is gathered. The framer then presents one record: the page, the opcode, up to three operand bytes, the mode code, the total byte length and an illegal flag.

It does not execute anything, count cycles or fetch from memory. An opcode that is not defined on its page is flagged and framed with no operands, so the framer always regains byte alignment on the following byte. A downstream decoder consumes one record per handshake. While a record is waiting, the framer holds it and refuses input.

Top module: `prefixed_insn_framer`

## Requirements
- R1: A first byte of 0x18, 0x1A or 0xCD is taken as a page prefix, and the byte after it is the opcode. `out_page` reports 1, 2 or 3 for these prefixes, and 0 when no prefix was seen.
- R2: `out_mode` codes are: 0 inherent, 1 one-byte immediate, 2 two-byte immediate, 3 direct, 4 extended, 5 indexed-X, 6 indexed-Y, 7 relative, 8 direct bit set/clear, 9 direct branch-on-bit, 10 X bit set/clear, 11 X branch-on-bit, 12 Y bit set/clear, 13 Y branch-on-bit. The operand count is 0 for inherent; 1 for codes 1, 3, 5, 6 and 7; 2 for codes 2, 4, 8, 10 and 12; and 3 for codes 9, 11 and 13. `out_len` is 1, plus 1 if there is a prefix, plus the operand count.
- R3: Operand bytes appear in `out_opers` in arrival order. The first byte goes in bits 7:0, the second in 15:8 and the third in 23:16, so a 16-bit value has its high byte in bits 7:0. Unused slots read zero.
- R4: Two-byte immediates are used by unprefixed 0x83, 0x8C, 0x8E, 0xC3, 0xCC and 0xCE, by page-1 0x8C and 0xCE, and by page-2 0x83. Every other immediate opcode takes one byte.
- R5: The bit forms take an address or offset byte, then a mask byte. The branch-on-bit forms add an offset byte after those. Unprefixed: 0x14/0x15 are mode 8, 0x12/0x13 mode 9, 0x1C/0x1D mode 10 and 0x1E/0x1F mode 11. Page 1: 0x1C/0x1D are mode 12 and 0x1E/0x1F mode 13.
- R6: On page 1, opcodes 0xA0-0xAF and 0xE0-0xEF, and those 0x6n with n not 1, 2, 5 or B, report mode 6 with one operand byte.
- R7: Page 2 accepts only 0x83 (mode 2), 0x93 (mode 3), 0xB3 (mode 4), and 0xA3, 0xAC, 0xEE and 0xEF (mode 5). Page 3 accepts only 0xA3, 0xAC, 0xEE and 0xEF (mode 6).
- R8: These unprefixed opcodes are illegal: 0x41, 0x42, 0x45, 0x4B, 0x4E, 0x51, 0x52, 0x55, 0x5B, 0x5E, 0x61, 0x62, 0x65, 0x6B, 0x71, 0x72, 0x75, 0x7B, 0x87 and 0xC7. Each is framed with `out_illegal` = 1, mode 0, length 1 and zero operands.
- R9: If the byte after a prefix is not defined on that page, the pair is framed with `out_illegal` = 1, mode 0 and length 2. The next byte starts a new instruction.
- R10: `out_valid` rises in the cycle after the last byte of an instruction is accepted. The record stays unchanged until `out_ready` is seen high. `in_ready` is low while `out_valid` is high, and bytes offered during that time are ignored.
- R11: A synchronous reset drops any partly collected instruction, clears `out_valid` and leaves `in_ready` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte offered |
| in_byte | input | BYTE_W | Instruction stream byte |
| in_ready | output | 1 | Framer takes the byte this cycle |
| out_valid | output | 1 | Record available |
| out_ready | input | 1 | Consumer takes the record |
| out_page | output | 2 | Opcode page (0 none, 1..3 prefix) |
| out_opcode | output | BYTE_W | Opcode byte after any prefix |
| out_opers | output | MAX_OPR*BYTE_W | Operand bytes, first in low bits |
| out_mode | output | 4 | Addressing-mode code |
| out_len | output | LEN_W | Total instruction length in bytes |
| out_illegal | output | 1 | Opcode not defined on its page |

## Verification
A wrong operand count or a stale collection state shows up as misframing. Either an operand byte appears as the opcode of the next record, or a record arrives one handshake early or late, so the error is visible no later than the record that follows. A misdecoded page or mode shows in the page, mode or length fields of the same record. A pending-record or stall fault shows as `in_ready` staying low, or as a changed field, within the few cycles the consumer holds `out_ready` low. The sweep frames every opcode value on every page, each followed directly by the next instruction, so both kinds of error are exposed at once.

// File: rtl/pif_pkg.sv
package pif_pkg;

   typedef enum logic [3:0] {
      M_INH      = 4'd0,
      M_IMM8     = 4'd1,
      M_IMM16    = 4'd2,
      M_DIR      = 4'd3,
      M_EXT      = 4'd4,
      M_IDX      = 4'd5,
      M_IDY      = 4'd6,
      M_REL      = 4'd7,
      M_DIR_BIT  = 4'd8,
      M_DIR_BRB  = 4'd9,
      M_IDX_BIT  = 4'd10,
      M_IDX_BRB  = 4'd11,
      M_IDY_BIT  = 4'd12,
      M_IDY_BRB  = 4'd13
   } pif_mode_e;

   localparam logic [1:0] PG_BASE = 2'd0;
   localparam logic [1:0] PG_Y    = 2'd1;
   localparam logic [1:0] PG_D    = 2'd2;
   localparam logic [1:0] PG_I    = 2'd3;

   // operand bytes that follow the opcode for each mode
   function automatic logic [1:0] pif_oper_count(input pif_mode_e m);
      case (m)
         M_INH:                                 return 2'd0;
         M_IMM16, M_EXT,
         M_DIR_BIT, M_IDX_BIT, M_IDY_BIT:       return 2'd2;
         M_DIR_BRB, M_IDX_BRB, M_IDY_BRB:       return 2'd3;
         default:                               return 2'd1;
      endcase
   endfunction

endpackage

// File: rtl/pif_classifier.sv
module pif_classifier
   import pif_pkg::*;
#(
   parameter int              BYTE_W = 8,
   parameter logic [7:0]      PFX_Y  = 8'h18,
   parameter logic [7:0]      PFX_D  = 8'h1A,
   parameter logic [7:0]      PFX_I  = 8'hCD
) (
   input  logic [1:0]        page,
   input  logic [BYTE_W-1:0] opc,
   output logic              is_pfx,
   output logic [1:0]        pfx_page,
   output logic              legal,
   output pif_mode_e         mode,
   output logic [1:0]        n_opr
);

   // legal low nibbles of the single-operand read-modify-write rows
   localparam logic [15:0] ACC_ROW_OK = 16'hB7D9;
   localparam logic [15:0] MEM_ROW_OK = 16'hF7D9;

   logic [3:0] hi;
   logic [3:0] lo;

   assign hi = opc[7:4];
   assign lo = opc[3:0];

   always_comb begin
      is_pfx   = 1'b0;
      pfx_page = PG_BASE;
      legal    = 1'b0;
      mode     = M_INH;
      case (page)
         PG_BASE: begin
            legal = 1'b1;
            if (opc == PFX_Y) begin
               is_pfx = 1'b1; pfx_page = PG_Y; legal = 1'b0;
            end else if (opc == PFX_D) begin
               is_pfx = 1'b1; pfx_page = PG_D; legal = 1'b0;
            end else if (opc == PFX_I) begin
               is_pfx = 1'b1; pfx_page = PG_I; legal = 1'b0;
            end else begin
               case (hi)
                  4'h0, 4'h3: mode = M_INH;
                  4'h1: begin
                     case (lo)
                        4'h2, 4'h3: mode = M_DIR_BRB;
                        4'h4, 4'h5: mode = M_DIR_BIT;
                        4'hC, 4'hD: mode = M_IDX_BIT;
                        4'hE, 4'hF: mode = M_IDX_BRB;
                        default:    mode = M_INH;
                     endcase
                  end
                  4'h2: mode = M_REL;
                  4'h4, 4'h5: begin
                     mode  = M_INH;
                     legal = ACC_ROW_OK[lo];
                  end
                  4'h6: begin
                     mode  = M_IDX;
                     legal = MEM_ROW_OK[lo];
                  end
                  4'h7: begin
                     mode  = M_EXT;
                     legal = MEM_ROW_OK[lo];
                  end
                  4'h8, 4'hC: begin
                     if (lo == 4'h7)
                        legal = 1'b0;
                     else if (lo == 4'h3 || lo == 4'hC || lo == 4'hE)
                        mode = M_IMM16;
                     else if (lo == 4'hF)
                        mode = M_INH;
                     else if (lo == 4'hD)
                        mode = M_REL;
                     else
                        mode = M_IMM8;
                  end
                  4'h9, 4'hD: mode = M_DIR;
                  4'hA, 4'hE: mode = M_IDX;
                  default:    mode = M_EXT;
               endcase
            end
         end
         PG_Y: begin
            case (hi)
               4'h0: begin
                  legal = (lo == 4'h8) || (lo == 4'h9);
               end
               4'h1: begin
                  if (lo == 4'hC || lo == 4'hD) begin
                     legal = 1'b1; mode = M_IDY_BIT;
                  end else if (lo == 4'hE || lo == 4'hF) begin
                     legal = 1'b1; mode = M_IDY_BRB;
                  end
               end
               4'h3: begin
                  legal = (lo == 4'h0) || (lo == 4'h5) || (lo == 4'h8) ||
                          (lo == 4'hA) || (lo == 4'hC);
               end
               4'h6: begin
                  legal = MEM_ROW_OK[lo];
                  mode  = M_IDY;
               end
               4'h8: begin
                  if (lo == 4'hC) begin
                     legal = 1'b1; mode = M_IMM16;
                  end else if (lo == 4'hF) begin
                     legal = 1'b1;
                  end
               end
               4'h9: begin
                  legal = (lo == 4'hC);
                  mode  = M_DIR;
               end
               4'hA, 4'hE: begin
                  legal = 1'b1;
                  mode  = M_IDY;
               end
               4'hB: begin
                  legal = (lo == 4'hC);
                  mode  = M_EXT;
               end
               4'hC: begin
                  legal = (lo == 4'hE);
                  mode  = M_IMM16;
               end
               4'hD: begin
                  legal = (lo == 4'hE) || (lo == 4'hF);
                  mode  = M_DIR;
               end
               4'hF: begin
                  legal = (lo == 4'hE) || (lo == 4'hF);
                  mode  = M_EXT;
               end
               default: legal = 1'b0;
            endcase
         end
         PG_D: begin
            case (opc)
               8'h83: begin legal = 1'b1; mode = M_IMM16; end
               8'h93: begin legal = 1'b1; mode = M_DIR;   end
               8'hB3: begin legal = 1'b1; mode = M_EXT;   end
               8'hA3, 8'hAC, 8'hEE, 8'hEF: begin
                  legal = 1'b1; mode = M_IDX;
               end
               default: legal = 1'b0;
            endcase
         end
         default: begin
            case (opc)
               8'hA3, 8'hAC, 8'hEE, 8'hEF: begin
                  legal = 1'b1; mode = M_IDY;
               end
               default: legal = 1'b0;
            endcase
         end
      endcase
      if (!legal)
         mode = M_INH;
   end

   assign n_opr = legal ? pif_oper_count(mode) : 2'd0;

   // R1: a prefix is never also an opcode, and only the base page knows prefixes
   always_comb begin
      if (is_pfx) begin
         assert_pfx_not_opcode_R1: assert (!legal && page == PG_BASE && pfx_page != PG_BASE);
      end
   end

endmodule

// File: rtl/pif_sequencer.sv
module pif_sequencer
   import pif_pkg::*;
#(
   parameter int BYTE_W  = 8,
   parameter int MAX_OPR = 3,
   parameter int LEN_W   = 3,
   localparam int SLOT_W = $clog2(MAX_OPR + 1)
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      in_valid,
   input  logic [BYTE_W-1:0]         in_byte,
   input  logic                      take_ok,
   output logic [1:0]                cls_page,
   input  logic                      cls_pfx,
   input  logic [1:0]                cls_pfx_page,
   input  logic                      cls_legal,
   input  pif_mode_e                 cls_mode,
   input  logic [1:0]                cls_nopr,
   output logic                      emit,
   output logic [1:0]                rec_page,
   output logic [BYTE_W-1:0]         rec_opc,
   output logic [MAX_OPR*BYTE_W-1:0] rec_ops,
   output pif_mode_e                 rec_mode,
   output logic [LEN_W-1:0]          rec_len,
   output logic                      rec_ill
);

   typedef enum logic [1:0] {S_OPC, S_PAGE, S_OPR} seq_st_e;

   seq_st_e                            st_q, st_d;
   logic [1:0]                         page_q, page_d;
   logic [BYTE_W-1:0]                  opc_q, opc_d;
   pif_mode_e                          mode_q, mode_d;
   logic [SLOT_W-1:0]                  slot_q, slot_d;
   logic [SLOT_W-1:0]                  left_q, left_d;
   logic [MAX_OPR-1:0][BYTE_W-1:0]     ops_q, ops_d, ops_fill;
   logic                               acc;
   logic [LEN_W-1:0]                   pfx_len;

   assign acc = in_valid & take_ok;

   // slot that receives the current byte while operands are being gathered
   for (genvar k = 0; k < MAX_OPR; k++) begin : g_slot
      assign ops_fill[k] = (slot_q == SLOT_W'(k)) ? in_byte : ops_q[k];
   end

   assign cls_page = (st_q == S_PAGE) ? page_q : PG_BASE;
   assign pfx_len  = (cls_page != PG_BASE) ? LEN_W'(2) : LEN_W'(1);

   always_comb begin
      st_d     = st_q;
      page_d   = page_q;
      opc_d    = opc_q;
      mode_d   = mode_q;
      slot_d   = slot_q;
      left_d   = left_q;
      ops_d    = ops_q;
      emit     = 1'b0;
      rec_page = cls_page;
      rec_opc  = in_byte;
      rec_ops  = '0;
      rec_mode = M_INH;
      rec_len  = pfx_len;
      rec_ill  = 1'b0;
      if (acc) begin
         case (st_q)
            S_OPC, S_PAGE: begin
               if (cls_pfx) begin
                  page_d = cls_pfx_page;
                  st_d   = S_PAGE;
               end else if (!cls_legal || cls_nopr == 2'd0) begin
                  emit    = 1'b1;
                  rec_ill = !cls_legal;
                  rec_mode = cls_mode;
                  page_d  = PG_BASE;
                  st_d    = S_OPC;
               end else begin
                  page_d = cls_page;
                  opc_d  = in_byte;
                  mode_d = cls_mode;
                  slot_d = '0;
                  left_d = SLOT_W'(cls_nopr);
                  ops_d  = '0;
                  st_d   = S_OPR;
               end
            end
            default: begin
               ops_d = ops_fill;
               if (left_q == SLOT_W'(1)) begin
                  emit     = 1'b1;
                  rec_page = page_q;
                  rec_opc  = opc_q;
                  rec_ops  = ops_fill;
                  rec_mode = mode_q;
                  rec_len  = ((page_q != PG_BASE) ? LEN_W'(2) : LEN_W'(1)) +
                             LEN_W'(slot_q) + LEN_W'(1);
                  page_d   = PG_BASE;
                  st_d     = S_OPC;
               end else begin
                  slot_d = slot_q + SLOT_W'(1);
                  left_d = left_q - SLOT_W'(1);
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= S_OPC;
         page_q <= PG_BASE;
         opc_q  <= '0;
         mode_q <= M_INH;
         slot_q <= '0;
         left_q <= '0;
         ops_q  <= '0;
      end else begin
         st_q   <= st_d;
         page_q <= page_d;
         opc_q  <= opc_d;
         mode_q <= mode_d;
         slot_q <= slot_d;
         left_q <= left_d;
         ops_q  <= ops_d;
      end
   end

   // R2: while gathering, the slots used plus those left equal the mode's count
   assert_count_track_R2: assert property (@(posedge clk) disable iff (rst)
      (st_q == S_OPR) |-> (left_q != '0) &&
         (32'(slot_q) + 32'(left_q) == 32'(pif_oper_count(mode_q))));

   // R9: after any record is cut, the next byte is read as a fresh opcode
   assert_resync_R9: assert property (@(posedge clk) disable iff (rst)
      emit |=> (st_q == S_OPC) && (page_q == PG_BASE));

   // R11: reset leaves no partial instruction
   assert_reset_idle_R11: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (st_q == S_OPC) && (left_q == '0));

endmodule

// File: rtl/pif_record.sv
module pif_record
   import pif_pkg::*;
#(
   parameter int BYTE_W  = 8,
   parameter int MAX_OPR = 3,
   parameter int LEN_W   = 3
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      emit,
   input  logic [1:0]                rec_page,
   input  logic [BYTE_W-1:0]         rec_opc,
   input  logic [MAX_OPR*BYTE_W-1:0] rec_ops,
   input  pif_mode_e                 rec_mode,
   input  logic [LEN_W-1:0]          rec_len,
   input  logic                      rec_ill,
   input  logic                      out_ready,
   output logic                      out_valid,
   output logic [1:0]                out_page,
   output logic [BYTE_W-1:0]         out_opcode,
   output logic [MAX_OPR*BYTE_W-1:0] out_opers,
   output logic [3:0]                out_mode,
   output logic [LEN_W-1:0]          out_len,
   output logic                      out_illegal
);

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid   <= 1'b0;
         out_page    <= PG_BASE;
         out_opcode  <= '0;
         out_opers   <= '0;
         out_mode    <= 4'(M_INH);
         out_len     <= '0;
         out_illegal <= 1'b0;
      end else if (emit) begin
         out_valid   <= 1'b1;
         out_page    <= rec_page;
         out_opcode  <= rec_opc;
         out_opers   <= rec_ops;
         out_mode    <= 4'(rec_mode);
         out_len     <= rec_len;
         out_illegal <= rec_ill;
      end else if (out_ready) begin
         out_valid   <= 1'b0;
      end
   end

   // R10: an unaccepted record keeps every field
   assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> out_valid && $stable(out_page) &&
         $stable(out_opcode) && $stable(out_opers) && $stable(out_mode) &&
         $stable(out_len) && $stable(out_illegal));

   // R10: no new record is cut while one is pending
   assert_single_pending_R10: assert property (@(posedge clk) disable iff (rst)
      emit |-> !out_valid);

   // R2: length stays within one opcode plus prefix plus the operand slots
   assert_len_range_R2: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_len >= LEN_W'(1)) && (32'(out_len) <= MAX_OPR + 2));

   // R8: an illegal record carries no operands and the bare byte count
   assert_illegal_shape_R8: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_illegal) |-> (out_mode == 4'(M_INH)) && (out_opers == '0) &&
         (out_len == ((out_page != PG_BASE) ? LEN_W'(2) : LEN_W'(1))));

   // R11: the cycle after reset holds no record
   assert_reset_empty_R11: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !out_valid);

endmodule

// File: rtl/prefixed_insn_framer.sv
module prefixed_insn_framer
   import pif_pkg::*;
#(
   parameter int         BYTE_W  = 8,
   parameter int         MAX_OPR = 3,
   parameter logic [7:0] PFX_Y   = 8'h18,
   parameter logic [7:0] PFX_D   = 8'h1A,
   parameter logic [7:0] PFX_I   = 8'hCD,
   localparam int        LEN_W   = $clog2(MAX_OPR + 3)
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      in_valid,
   input  logic [BYTE_W-1:0]         in_byte,
   output logic                      in_ready,
   output logic                      out_valid,
   input  logic                      out_ready,
   output logic [1:0]                out_page,
   output logic [BYTE_W-1:0]         out_opcode,
   output logic [MAX_OPR*BYTE_W-1:0] out_opers,
   output logic [3:0]                out_mode,
   output logic [LEN_W-1:0]          out_len,
   output logic                      out_illegal
);

   if (BYTE_W != 8) begin : g_bad_width
      $error("prefixed_insn_framer: opcode decoding needs BYTE_W of 8");
   end
   if (MAX_OPR < 3) begin : g_bad_slots
      $error("prefixed_insn_framer: branch-on-bit forms need three operand slots");
   end
   if (PFX_Y == PFX_D || PFX_D == PFX_I || PFX_Y == PFX_I) begin : g_bad_pfx
      $error("prefixed_insn_framer: prefix byte values must differ");
   end

   logic [1:0]                cls_page;
   logic                      cls_pfx;
   logic [1:0]                cls_pfx_page;
   logic                      cls_legal;
   pif_mode_e                 cls_mode;
   logic [1:0]                cls_nopr;
   logic                      emit;
   logic [1:0]                rec_page;
   logic [BYTE_W-1:0]         rec_opc;
   logic [MAX_OPR*BYTE_W-1:0] rec_ops;
   pif_mode_e                 rec_mode;
   logic [LEN_W-1:0]          rec_len;
   logic                      rec_ill;

   assign in_ready = !out_valid;

   pif_classifier #(
      .BYTE_W (BYTE_W),
      .PFX_Y  (PFX_Y),
      .PFX_D  (PFX_D),
      .PFX_I  (PFX_I)
   ) u_cls (
      .page     (cls_page),
      .opc      (in_byte),
      .is_pfx   (cls_pfx),
      .pfx_page (cls_pfx_page),
      .legal    (cls_legal),
      .mode     (cls_mode),
      .n_opr    (cls_nopr)
   );

   pif_sequencer #(
      .BYTE_W  (BYTE_W),
      .MAX_OPR (MAX_OPR),
      .LEN_W   (LEN_W)
   ) u_seq (
      .clk          (clk),
      .rst          (rst),
      .in_valid     (in_valid),
      .in_byte      (in_byte),
      .take_ok      (in_ready),
      .cls_page     (cls_page),
      .cls_pfx      (cls_pfx),
      .cls_pfx_page (cls_pfx_page),
      .cls_legal    (cls_legal),
      .cls_mode     (cls_mode),
      .cls_nopr     (cls_nopr),
      .emit         (emit),
      .rec_page     (rec_page),
      .rec_opc      (rec_opc),
      .rec_ops      (rec_ops),
      .rec_mode     (rec_mode),
      .rec_len      (rec_len),
      .rec_ill      (rec_ill)
   );

   pif_record #(
      .BYTE_W  (BYTE_W),
      .MAX_OPR (MAX_OPR),
      .LEN_W   (LEN_W)
   ) u_rec (
      .clk         (clk),
      .rst         (rst),
      .emit        (emit),
      .rec_page    (rec_page),
      .rec_opc     (rec_opc),
      .rec_ops     (rec_ops),
      .rec_mode    (rec_mode),
      .rec_len     (rec_len),
      .rec_ill     (rec_ill),
      .out_ready   (out_ready),
      .out_valid   (out_valid),
      .out_page    (out_page),
      .out_opcode  (out_opcode),
      .out_opers   (out_opers),
      .out_mode    (out_mode),
      .out_len     (out_len),
      .out_illegal (out_illegal)
   );

   // R10: input is refused for as long as a record waits
   assert_stall_R10: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> !in_ready);

endmodule

// File: tb/prefixed_insn_framer_test.sv
module prefixed_insn_framer_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [7:0]  in_byte = 8'h00;
   logic        out_ready = 1'b0;
   logic        in_ready;
   logic        out_valid;
   logic [1:0]  out_page;
   logic [7:0]  out_opcode;
   logic [23:0] out_opers;
   logic [3:0]  out_mode;
   logic [2:0]  out_len;
   logic        out_illegal;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   prefixed_insn_framer uut (
      .clk (clk), .rst (rst), .in_valid (in_valid), .in_byte (in_byte),
      .in_ready (in_ready), .out_valid (out_valid), .out_ready (out_ready),
      .out_page (out_page), .out_opcode (out_opcode), .out_opers (out_opers),
      .out_mode (out_mode), .out_len (out_len), .out_illegal (out_illegal)
   );

   task automatic chk_eq(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic bit hole0(input int op);
      case (op)
         'h41, 'h42, 'h45, 'h4B, 'h4E, 'h51, 'h52, 'h55, 'h5B, 'h5E,
         'h61, 'h62, 'h65, 'h6B, 'h71, 'h72, 'h75, 'h7B, 'h87, 'hC7: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   // independent reference: mode codes and legality per the requirement list
   function automatic void ref_class(input int pg, input int op, output bit ok, output int md);
      int hi, lo;
      hi = op / 16;
      lo = op % 16;
      ok = 1'b0;
      md = 0;
      if (pg == 0) begin
         ok = !hole0(op);
         if (hi == 1 && (lo == 2 || lo == 3)) md = 9;
         else if (hi == 1 && (lo == 4 || lo == 5)) md = 8;
         else if (hi == 1 && (lo == 12 || lo == 13)) md = 10;
         else if (hi == 1 && lo >= 14) md = 11;
         else if (hi == 2) md = 7;
         else if (hi == 6) md = 5;
         else if (hi == 7) md = 4;
         else if (op == 'h83 || op == 'h8C || op == 'h8E || op == 'hC3 || op == 'hCC || op == 'hCE) md = 2;
         else if (op == 'h8D) md = 7;
         else if (op == 'h8F || op == 'hCF) md = 0;
         else if (hi == 8 || hi == 12) md = 1;
         else if (hi == 9 || hi == 13) md = 3;
         else if (hi == 10 || hi == 14) md = 5;
         else if (hi == 11 || hi == 15) md = 4;
         else md = 0;
      end else if (pg == 1) begin
         if (op == 'h08 || op == 'h09 || op == 'h30 || op == 'h35 || op == 'h38 ||
             op == 'h3A || op == 'h3C || op == 'h8F) begin ok = 1; md = 0; end
         else if (op == 'h1C || op == 'h1D) begin ok = 1; md = 12; end
         else if (op == 'h1E || op == 'h1F) begin ok = 1; md = 13; end
         else if (hi == 6 && !(lo == 1 || lo == 2 || lo == 5 || lo == 11)) begin ok = 1; md = 6; end
         else if (hi == 10 || hi == 14) begin ok = 1; md = 6; end
         else if (op == 'h8C || op == 'hCE) begin ok = 1; md = 2; end
         else if (op == 'h9C || op == 'hDE || op == 'hDF) begin ok = 1; md = 3; end
         else if (op == 'hBC || op == 'hFE || op == 'hFF) begin ok = 1; md = 4; end
      end else if (pg == 2) begin
         if (op == 'h83) begin ok = 1; md = 2; end
         else if (op == 'h93) begin ok = 1; md = 3; end
         else if (op == 'hB3) begin ok = 1; md = 4; end
         else if (op == 'hA3 || op == 'hAC || op == 'hEE || op == 'hEF) begin ok = 1; md = 5; end
      end else begin
         if (op == 'hA3 || op == 'hAC || op == 'hEE || op == 'hEF) begin ok = 1; md = 6; end
      end
      if (!ok) md = 0;
   endfunction

   function automatic int ref_count(input int md);
      if (md == 0) return 0;
      if (md == 2 || md == 4 || md == 8 || md == 10 || md == 12) return 2;
      if (md == 9 || md == 11 || md == 13) return 3;
      return 1;
   endfunction

   task automatic push(input logic [7:0] b);
      int guard;
      guard = 0;
      while (!in_ready && guard < 8) begin
         @(negedge clk);
         guard++;
      end
      if (!in_ready) begin
         chk_eq("R10", "input not released (early record)", 0, 1);
         out_ready = 1'b1;
         @(negedge clk);
         out_ready = 1'b0;
      end
      in_valid = 1'b1;
      in_byte  = b;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic pop();
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
      chk_eq("R10", "valid drops after accept", int'(out_valid), 0);
   endtask

   task automatic run_one(input int pg, input int op);
      bit ok;
      int md, n, len;
      string tag;
      logic [23:0] exp_ops;
      logic [7:0] b;
      ref_class(pg, op, ok, md);
      n = ok ? ref_count(md) : 0;
      len = 1 + ((pg != 0) ? 1 : 0) + n;
      exp_ops = '0;
      if (pg == 1) push(8'h18);
      else if (pg == 2) push(8'h1A);
      else if (pg == 3) push(8'hCD);
      push(8'(op));
      for (int k = 0; k < n; k++) begin
         b = 8'(op * 7 + pg * 29 + k * 83 + 1);
         exp_ops[k*8 +: 8] = b;
         push(b);
      end
      if (!ok) tag = (pg == 0) ? "R8" : "R9";
      else if (md >= 8) tag = "R5";
      else if (md == 2) tag = "R4";
      else if (pg == 1 && md == 6) tag = "R6";
      else if (pg >= 2) tag = "R7";
      else tag = "R2";
      chk_eq("R10", "valid after last byte", int'(out_valid), 1);
      chk_eq("R1", "page", int'(out_page), pg);
      chk_eq(tag, "opcode", int'(out_opcode), op);
      chk_eq(tag, "mode", int'(out_mode), md);
      chk_eq(tag, "length", int'(out_len), len);
      chk_eq(tag, "illegal flag", int'(out_illegal), ok ? 0 : 1);
      chk_eq("R3", "operands", int'(out_opers), int'(exp_ops));
      pop();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [23:0] h_ops;
      logic [3:0]  h_mode;
      logic [7:0]  h_opc;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      chk_eq("R11", "reset out_valid", int'(out_valid), 0);
      chk_eq("R11", "reset in_ready", int'(in_ready), 1);

      // full sweep: every byte value on every page
      for (int pg = 0; pg < 4; pg++) begin
         for (int op = 0; op < 256; op++) begin
            if (pg == 0 && (op == 'h18 || op == 'h1A || op == 'hCD)) continue;
            run_one(pg, op);
         end
      end

      // R10: hold with consumer stalled while bytes are offered
      push(8'h18); push(8'h1E); push(8'hA1); push(8'hB2); push(8'hC3);
      h_ops = out_opers; h_mode = out_mode; h_opc = out_opcode;
      in_valid = 1'b1; in_byte = 8'h01;
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         chk_eq("R10", "held valid", int'(out_valid), 1);
         chk_eq("R10", "stall in_ready", int'(in_ready), 0);
         chk_eq("R10", "held operands", int'(out_opers), int'(h_ops));
         chk_eq("R10", "held opcode", int'(out_opcode), int'(h_opc));
         chk_eq("R10", "held mode", int'(out_mode), int'(h_mode));
      end
      in_valid = 1'b0;
      chk_eq("R5", "held length", int'(out_len), 5);
      pop();
      push(8'h4C);
      chk_eq("R10", "byte after stall opcode", int'(out_opcode), 'h4C);
      chk_eq("R10", "byte after stall length", int'(out_len), 1);
      pop();

      // R9: illegal pair then resync onto a normal instruction
      push(8'h1A); push(8'h86);
      chk_eq("R9", "pair illegal", int'(out_illegal), 1);
      chk_eq("R9", "pair length", int'(out_len), 2);
      pop();
      push(8'h86); push(8'h33);
      chk_eq("R9", "resync page", int'(out_page), 0);
      chk_eq("R9", "resync mode", int'(out_mode), 1);
      chk_eq("R9", "resync operand", int'(out_opers), 'h33);
      pop();

      // R11: reset in the middle of an instruction
      push(8'h18); push(8'hCE); push(8'h12);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      chk_eq("R11", "mid reset out_valid", int'(out_valid), 0);
      chk_eq("R11", "mid reset in_ready", int'(in_ready), 1);
      push(8'h86); push(8'h44);
      chk_eq("R11", "after reset page", int'(out_page), 0);
      chk_eq("R11", "after reset opcode", int'(out_opcode), 'h86);
      chk_eq("R11", "after reset length", int'(out_len), 2);
      chk_eq("R11", "after reset operand", int'(out_opers), 'h44);
      pop();

      finish_run();
   end

endmodule